// File: doc/BRIEF.md
# I2C Interrupt Status Aggregator

This block holds the interrupt status word of every bus in a multi-bus I2C controller and folds the buses into a single controller interrupt. One-cycle event pulses from each bus engine set individual status bits. Software clears bits by writing ones to the status register of a chosen bus. A write to that bus's command register also wipes its status, except for the receive-done flag, which survives so that a byte still waiting to be read is not lost.

Each bus owns one bit of a summary vector, at the position equal to its bus index. The controller interrupt is the OR of the summary vector. A bus's summary bit rises with any event on that bus. It falls only after a status-clear write that leaves every status bit of the bus at zero. While receive-done is set, the bus engine is told not to deliver another received byte.

A read port returns the status word of any bus. Two live slave-match indications from the bus engine sit in the top bits of that word. They are read-only.

Top module: `i2c_irq_aggregator`

## Requirements
- R1: After reset every status word reads zero, the summary vector is zero, `irq_o` is low and every `rx_ok_o` bit is high.
- R2: An event pulse on an implemented status bit of bus b sets that bit at the next clock edge and sets summary bit b in the same edge. The implemented bits are 0 (transmit ACK), 1 (transmit NAK), 2 (receive done), 3 (arbitration lost), 4 (normal stop), 5 (abnormal condition), 6 (clock-line timeout), 7 (slave address match), 13 (bus recovery done), 14 (data-line stuck-low timeout) and 15 (slave inactive timeout). Pulses on bits 8 to 12 have no effect, and those bits read as zero.
- R3: A status write (`wr_en_i`=1, `wr_cmd_i`=0) with data d clears each status bit in 14:0 where d has a one. Bit 15 and every data bit above 14 have no effect.
- R4: After a status write to bus b, summary bit b falls only if all sixteen status bits of bus b are zero. Otherwise it stays high. `irq_o` is high whenever any summary bit is high.
- R5: A command write (`wr_en_i`=1, `wr_cmd_i`=1) to bus b clears status bits 15:0 of bus b, except bit 2 (receive done), which keeps its value.
- R6: A command write does not change the summary bit. A summary bit left high with a zero status falls at the next status write to that bus.
- R7: When an event pulse and a clearing write (of either kind) hit the same bit in one cycle, the bit ends up set and the summary bit stays high.
- R8: `rx_ok_o[b]` is low exactly while status bit 2 of bus b is set.
- R9: The read word of bus b carries status bits 15:0 in bits 15:0. Bit 31 carries `slv_addr_sel_i[b]` (0 = first address, 1 = second address) and bit 30 carries `slv_rx_pend_i[b]`. Bits 29:16 read zero. No write changes bits 31:30.
- R10: A write addressed to bus b changes neither the status nor the summary bit of any other bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_set_i | input | NUM_BUS*16 | Event pulses; bus b uses bits [b*16 +: 16] |
| slv_addr_sel_i | input | NUM_BUS | Live: which slave address matched, per bus |
| slv_rx_pend_i | input | NUM_BUS | Live: slave address receive pending, per bus |
| wr_en_i | input | 1 | Register write strobe |
| wr_cmd_i | input | 1 | 1 = command register write, 0 = status clear write |
| wr_bus_i | input | BIDX_W | Bus addressed by the write |
| wr_data_i | input | 32 | Write data |
| rd_bus_i | input | BIDX_W | Bus whose status word is read |
| rd_data_o | output | 32 | Status word of the selected bus |
| summary_o | output | NUM_BUS | Per-bus summary bits, bit b for bus b |
| irq_o | output | 1 | Shared controller interrupt |
| rx_ok_o | output | NUM_BUS | High when the bus may accept another received byte |

## Verification
The bench targets the clear that leaves one bit behind. A design that lowers the summary on every clear write would drop the interrupt there while bit 15, which the clear mask cannot reach, is still set. It also issues command writes with receive-done pending. A design that wipes the whole word there would lose the byte-waiting flag and reopen `rx_ok_o`, and one that lowers the summary on the command write would break R6. Same-cycle set and clear collisions are driven on both write kinds to catch a design where the clear wins and an event is lost. Writes aimed at one bus are checked against the other buses' state, and clear writes with all-ones data are checked against the read-only slave bits.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   // status word geometry
   localparam int STAT_W   = 16;
   localparam int WORD_W   = 32;
   // bit roles that the logic depends on
   localparam int RXD_BIT  = 2;
   localparam int SSEL_BIT = 31;
   localparam int SPND_BIT = 30;
   // bits that exist in hardware (0..7, 13..15)
   localparam logic [STAT_W-1:0] IMPL_MASK = 16'hE0FF;
   // bits a status write may clear (0..14)
   localparam logic [STAT_W-1:0] W1C_MASK  = 16'h7FFF;

   function automatic logic [WORD_W-1:0] pack_word(
      input logic [STAT_W-1:0] stat,
      input logic              ssel,
      input logic              spnd);
      logic [WORD_W-1:0] w;
      w                      = '0;
      w[STAT_W-1:0]          = stat;
      w[SSEL_BIT]            = ssel;
      w[SPND_BIT]            = spnd;
      return w;
   endfunction
endpackage

// File: rtl/i2c_irq_wr_decode.sv
module i2c_irq_wr_decode #(
   parameter int NUM_BUS = 4,
   parameter int BIDX_W  = 2
) (
   input  logic              wr_en_i,
   input  logic              wr_cmd_i,
   input  logic [BIDX_W-1:0] wr_bus_i,
   output logic [NUM_BUS-1:0] clr_hit_o,
   output logic [NUM_BUS-1:0] cmd_hit_o
);
   always_comb begin
      clr_hit_o = '0;
      cmd_hit_o = '0;
      for (int b = 0; b < NUM_BUS; b++) begin
         if (wr_en_i && (wr_bus_i == BIDX_W'(b))) begin
            clr_hit_o[b] = ~wr_cmd_i;
            cmd_hit_o[b] = wr_cmd_i;
         end
      end
   end
endmodule

// File: rtl/i2c_irq_bus_stat.sv
module i2c_irq_bus_stat
   import i2c_irq_pkg::*;
#(
   parameter int                STW       = STAT_W,
   parameter logic [STW-1:0]    IMPL      = IMPL_MASK,
   parameter logic [STW-1:0]    W1C       = W1C_MASK,
   parameter int                KEEP_BIT  = RXD_BIT
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [STW-1:0] ev_i,
   input  logic           clr_hit_i,
   input  logic           cmd_hit_i,
   input  logic [STW-1:0] wr_data_i,
   output logic [STW-1:0] stat_o,
   output logic           summ_o
);
   localparam logic [STW-1:0] CMD_KEEP = STW'(1) << KEEP_BIT;

   logic [STW-1:0] stat_q, stat_nxt, ev_m, keep;
   logic           summ_q, summ_nxt;

   always_comb begin
      ev_m = ev_i & IMPL;
      if (clr_hit_i)      keep = ~(wr_data_i & W1C);
      else if (cmd_hit_i) keep = CMD_KEEP;
      else                keep = '1;
      // set wins: events are OR'd after the clear
      stat_nxt = (stat_q & keep) | ev_m;
      if (|ev_m)          summ_nxt = 1'b1;
      else if (clr_hit_i) summ_nxt = |stat_nxt;
      else                summ_nxt = summ_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         summ_q <= 1'b0;
      end else begin
         stat_q <= stat_nxt;
         summ_q <= summ_nxt;
      end
   end

   assign stat_o = stat_q;
   assign summ_o = summ_q;
endmodule

// File: rtl/i2c_irq_rd_mux.sv
module i2c_irq_rd_mux #(
   parameter int NUM_BUS = 4,
   parameter int BIDX_W  = 2,
   parameter int WORD_W  = 32,
   parameter bit RD_REG  = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [BIDX_W-1:0]         rd_bus_i,
   input  logic [NUM_BUS*WORD_W-1:0] words_i,
   output logic [WORD_W-1:0]         rd_data_o
);
   logic [WORD_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int b = 0; b < NUM_BUS; b++) begin
         if (rd_bus_i == BIDX_W'(b)) sel = words_i[b*WORD_W +: WORD_W];
      end
   end

   generate
      if (RD_REG) begin : g_reg
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= sel;
         end
         assign rd_data_o = q;
      end else begin : g_comb
         assign rd_data_o = sel;
      end
   endgenerate
endmodule

// File: rtl/i2c_irq_aggregator.sv
module i2c_irq_aggregator
   import i2c_irq_pkg::*;
#(
   parameter int NUM_BUS = 4,
   parameter bit RD_REG  = 1'b0,
   parameter int BIDX_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_BUS*STAT_W-1:0] ev_set_i,
   input  logic [NUM_BUS-1:0]        slv_addr_sel_i,
   input  logic [NUM_BUS-1:0]        slv_rx_pend_i,
   input  logic                      wr_en_i,
   input  logic                      wr_cmd_i,
   input  logic [BIDX_W-1:0]         wr_bus_i,
   input  logic [WORD_W-1:0]         wr_data_i,
   input  logic [BIDX_W-1:0]         rd_bus_i,
   output logic [WORD_W-1:0]         rd_data_o,
   output logic [NUM_BUS-1:0]        summary_o,
   output logic                      irq_o,
   output logic [NUM_BUS-1:0]        rx_ok_o
);
   generate
      if (NUM_BUS < 1 || NUM_BUS > 32) begin : g_bad_num
         $error("NUM_BUS must lie in 1..32");
      end
      if ((1 << BIDX_W) < NUM_BUS) begin : g_bad_idx
         $error("BIDX_W too narrow for NUM_BUS");
      end
   endgenerate

   logic [NUM_BUS-1:0]        clr_hit, cmd_hit;
   logic [NUM_BUS*STAT_W-1:0] stat_all;
   logic [NUM_BUS-1:0]        summ_q;
   logic [NUM_BUS*WORD_W-1:0] words;

   i2c_irq_wr_decode #(.NUM_BUS(NUM_BUS), .BIDX_W(BIDX_W)) u_dec (
      .wr_en_i  (wr_en_i),
      .wr_cmd_i (wr_cmd_i),
      .wr_bus_i (wr_bus_i),
      .clr_hit_o(clr_hit),
      .cmd_hit_o(cmd_hit)
   );

   generate
      for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
         i2c_irq_bus_stat u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (ev_set_i[b*STAT_W +: STAT_W]),
            .clr_hit_i(clr_hit[b]),
            .cmd_hit_i(cmd_hit[b]),
            .wr_data_i(wr_data_i[STAT_W-1:0]),
            .stat_o   (stat_all[b*STAT_W +: STAT_W]),
            .summ_o   (summ_q[b])
         );
         assign words[b*WORD_W +: WORD_W] =
            pack_word(stat_all[b*STAT_W +: STAT_W], slv_addr_sel_i[b], slv_rx_pend_i[b]);
         assign rx_ok_o[b] = ~stat_all[b*STAT_W + RXD_BIT];
      end
   endgenerate

   i2c_irq_rd_mux #(.NUM_BUS(NUM_BUS), .BIDX_W(BIDX_W), .WORD_W(WORD_W), .RD_REG(RD_REG)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_bus_i (rd_bus_i),
      .words_i  (words),
      .rd_data_o(rd_data_o)
   );

   assign summary_o = summ_q;
   assign irq_o     = |summ_q;
endmodule

// File: rtl/i2c_irq_aggregator_chk.sv
module i2c_irq_aggregator_chk
   import i2c_irq_pkg::*;
#(
   parameter int NUM_BUS = 4,
   parameter int BIDX_W  = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_BUS*STAT_W-1:0] ev_set_i,
   input logic                      wr_en_i,
   input logic                      wr_cmd_i,
   input logic [BIDX_W-1:0]         wr_bus_i,
   input logic [NUM_BUS*STAT_W-1:0] stat_all,
   input logic [NUM_BUS-1:0]        summary_o
);
   localparam logic [NUM_BUS*STAT_W-1:0] ALL_IMPL = {NUM_BUS{IMPL_MASK}};

   // R2 R7
   ev_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_set_i & ALL_IMPL) != '0) |=>
      ((stat_all & $past(ev_set_i & ALL_IMPL)) == $past(ev_set_i & ALL_IMPL)));

   generate
      for (genvar b = 0; b < NUM_BUS; b++) begin : g_b
         // R4
         summ_covers_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_all[b*STAT_W +: STAT_W] != '0) |-> summary_o[b]);
         // R4
         clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !wr_cmd_i && wr_bus_i == BIDX_W'(b)) |=>
            (summary_o[b] == (stat_all[b*STAT_W +: STAT_W] != '0)));
         // R5
         cmd_keeps_rxd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_cmd_i && wr_bus_i == BIDX_W'(b)) |=>
            (stat_all[b*STAT_W +: STAT_W] ==
             (($past(stat_all[b*STAT_W +: STAT_W]) & 16'h0004) |
              ($past(ev_set_i[b*STAT_W +: STAT_W]) & IMPL_MASK))));
         // R6
         cmd_summ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_cmd_i && wr_bus_i == BIDX_W'(b) && $past(summary_o[b])) |=>
            summary_o[b]);
         // R3
         bit15_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !wr_cmd_i && stat_all[b*STAT_W + 15]) |=>
            stat_all[b*STAT_W + 15]);
      end
   endgenerate
endmodule

bind i2c_irq_aggregator i2c_irq_aggregator_chk #(.NUM_BUS(NUM_BUS), .BIDX_W(BIDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ev_set_i (ev_set_i),
   .wr_en_i  (wr_en_i),
   .wr_cmd_i (wr_cmd_i),
   .wr_bus_i (wr_bus_i),
   .stat_all (stat_all),
   .summary_o(summary_o)
);

// File: tb/i2c_irq_aggregator_test.sv
`timescale 1ns/1ps
module i2c_irq_aggregator_test;
   localparam int NB = 4;
   localparam int BW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NB*16-1:0] ev = '0;
   logic [NB-1:0]   ssel = '0, spnd = '0;
   logic            wr_en = 1'b0, wr_cmd = 1'b0;
   logic [BW-1:0]   wr_bus = '0, rd_bus = '0;
   logic [31:0]     wr_data = '0;
   logic [31:0]     rd_data;
   logic [NB-1:0]   summ, rx_ok;
   logic            irq;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   i2c_irq_aggregator #(.NUM_BUS(NB)) uut (
      .clk(clk), .rst_n(rst_n), .ev_set_i(ev),
      .slv_addr_sel_i(ssel), .slv_rx_pend_i(spnd),
      .wr_en_i(wr_en), .wr_cmd_i(wr_cmd), .wr_bus_i(wr_bus), .wr_data_i(wr_data),
      .rd_bus_i(rd_bus), .rd_data_o(rd_data),
      .summary_o(summ), .irq_o(irq), .rx_ok_o(rx_ok));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // one clock with optional event and write; sample after the edge
   task automatic cyc(input int bus_ev, input logic [15:0] evb,
                      input logic we, input logic cmd, input int wb, input logic [31:0] d);
      @(negedge clk);
      ev = '0;
      if (bus_ev >= 0) ev[bus_ev*16 +: 16] = evb;
      wr_en = we; wr_cmd = cmd; wr_bus = BW'(wb); wr_data = d;
      @(posedge clk);
      #1;
      ev = '0; wr_en = 1'b0; wr_cmd = 1'b0; wr_data = '0;
   endtask

   function automatic logic [31:0] rd(input int b);
      rd_bus = BW'(b);
      return 32'h0;
   endfunction

   task automatic rd_chk(input string req, input int b, input logic [31:0] exp);
      rd_bus = BW'(b);
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic t_reset;
      for (int b = 0; b < NB; b++) rd_chk("R1 status", b, 32'h0);
      chk("R1 summary", 32'(summ), 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 rx_ok", 32'(rx_ok), 32'hF);
   endtask

   task automatic t_set;
      cyc(1, 16'h8101, 1'b0, 1'b0, 0, 0);
      rd_chk("R2 set, bit 8 ignored", 1, 32'h0000_8001);
      chk("R2 summary", 32'(summ), 32'h2);
      chk("R4 irq", 32'(irq), 32'h1);
   endtask

   task automatic t_partial_clear;
      cyc(-1, 0, 1'b1, 1'b0, 1, 32'h0000_0001);
      rd_chk("R3 clear bit0", 1, 32'h0000_8000);
      chk("R4 summary held", 32'(summ), 32'h2);
      cyc(-1, 0, 1'b1, 1'b0, 1, 32'hFFFF_FFFF);
      rd_chk("R3 bit15 not clearable", 1, 32'h0000_8000);
      chk("R4 summary still held", 32'(summ), 32'h2);
   endtask

   task automatic t_cmd_then_clear;
      cyc(-1, 0, 1'b1, 1'b1, 1, 32'h0);
      rd_chk("R5 cmd wipes", 1, 32'h0);
      chk("R6 summary after cmd", 32'(summ), 32'h2);
      cyc(-1, 0, 1'b1, 1'b0, 1, 32'h0);
      chk("R4 summary released", 32'(summ), 32'h0);
      chk("R4 irq released", 32'(irq), 32'h0);
   endtask

   task automatic t_rx_done;
      cyc(2, 16'h0006, 1'b0, 1'b0, 0, 0);
      chk("R8 rx_ok low", 32'(rx_ok), 32'hB);
      cyc(-1, 0, 1'b1, 1'b1, 2, 32'hFFFF_FFFF);
      rd_chk("R5 rx done kept", 2, 32'h0000_0004);
      chk("R8 rx_ok still low", 32'(rx_ok), 32'hB);
      cyc(-1, 0, 1'b1, 1'b0, 2, 32'h0000_0004);
      rd_chk("R3 rx done cleared", 2, 32'h0);
      chk("R8 rx_ok back", 32'(rx_ok), 32'hF);
      chk("R4 summary bus2", 32'(summ), 32'h0);
   endtask

   task automatic t_set_wins;
      cyc(0, 16'h0008, 1'b0, 1'b0, 0, 0);
      cyc(0, 16'h0008, 1'b1, 1'b0, 0, 32'h0000_0008);
      rd_chk("R7 set beats clear", 0, 32'h0000_0008);
      chk("R7 summary", 32'(summ), 32'h1);
      cyc(0, 16'h0001, 1'b1, 1'b1, 0, 32'h0);
      rd_chk("R7 set beats cmd", 0, 32'h0000_0001);
      cyc(-1, 0, 1'b1, 1'b0, 0, 32'h0000_0001);
      chk("R4 bus0 released", 32'(summ), 32'h0);
   endtask

   task automatic t_isolate;
      cyc(0, 16'h0010, 1'b0, 1'b0, 0, 0);
      cyc(3, 16'h0020, 1'b0, 1'b0, 0, 0);
      chk("R2 two buses", 32'(summ), 32'h9);
      cyc(-1, 0, 1'b1, 1'b0, 0, 32'h0000_FFFF);
      rd_chk("R10 bus3 untouched", 3, 32'h0000_0020);
      chk("R10 summary bus3 only", 32'(summ), 32'h8);
      chk("R4 irq from bus3", 32'(irq), 32'h1);
      cyc(-1, 0, 1'b1, 1'b1, 1, 32'h0);
      rd_chk("R10 cmd on bus1 spares bus3", 3, 32'h0000_0020);
      cyc(-1, 0, 1'b1, 1'b0, 3, 32'h0000_0020);
      chk("R4 irq low", 32'(irq), 32'h0);
   endtask

   task automatic t_slave;
      @(negedge clk);
      ssel = 4'b0010; spnd = 4'b0010;
      rd_chk("R9 slave bits", 1, 32'hC000_0000);
      cyc(-1, 0, 1'b1, 1'b0, 1, 32'hFFFF_FFFF);
      rd_chk("R9 clear ignores slave bits", 1, 32'hC000_0000);
      cyc(-1, 0, 1'b1, 1'b1, 1, 32'hFFFF_FFFF);
      rd_chk("R9 cmd ignores slave bits", 1, 32'hC000_0000);
      chk("R9 no summary from slave bits", 32'(summ), 32'h0);
      @(negedge clk);
      ssel = 4'b0000;
      rd_chk("R9 address select follows input", 1, 32'h4000_0000);
      spnd = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_set();
      t_partial_clear();
      t_cmd_then_clear();
      t_rx_done();
      t_set_wins();
      t_isolate();
      t_slave();
      repeat (2) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule